// File: doc/BRIEF.md
# Configuration Access Request Sequencer

This block sits between a host that wants to read or write one register in the configuration space of a PCIe function and the programmed-I/O register port of a controller core. The host presents a bus, device and function number, a register offset, an access size of one, two or four bytes, right-justified write data and a one-cycle start pulse. The block decides whether the request may go out at all and, if so, picks the request type and packs the address. It builds the byte strobe and aligns the write data. It then drives the core through a clear, launch and poll sequence and turns the completion status it reads back into a result.

A request to a non-zero device number on the root bus cannot reach a real function, so it is answered inside the block and never shown to the core. Reads that end with Unsupported Request or Configuration Retry status are not failures. They return fixed placeholder words, which lets enumeration software treat an absent or not-yet-ready function as plain data. The core is polled a bounded number of times, with a fixed gap between polls, and a request that never completes ends with a timeout code. Only one request is in flight at a time, and `busy` covers it from acceptance to the result pulse.

Top module: `cfg_req_seq`

## Requirements
- R1: The 4-bit request type on `coreType` is 0x8 for a read and 0xA for a write when `reqBus` equals `rootBus` (type 0). It is 0x9 for a read and 0xB for a write on any other bus (type 1).
- R2: `coreAddrLo` carries the bus at bits 27:20, the device at bits 19:15, the function at bits 14:12 and offset bits 11:2 at bits 11:2. Bits 31:28 and 1:0 are zero, and `coreAddrHi` is zero.
- R3: `reqSize` 0, 1 and 2 (and 3) select 1, 2 and 4 bytes. `coreStrb` is a run of that many ones shifted left by offset[1:0] and cut to 4 bits. `coreWdata` is `reqWdata` shifted left by 8 times offset[1:0].
- R4: A request with `reqBus` equal to `rootBus` and a non-zero device is never issued: `coreClear` and `coreLaunch` stay low. The result pulse comes in the first cycle after acceptance with code ok. A read returns the all-ones value cut to the size, and a write returns zero.
- R5: For an issued request, `coreClear` is high for one cycle right after acceptance, and `coreLaunch` is high for one cycle in the cycle after that.
- R6: The transfer is finished when the start readback is 0 and the done flag is 1. The core is sampled at the end of the cycle after the launch cycle, and then every `POLL_GAP` cycles. The result pulse comes in the cycle after the first sample that sees the transfer finished.
- R7: If `MAX_POLLS` samples all fail, the result pulse follows the last one with code timeout (2) and data zero.
- R8: A read whose status field (bits 9:7) is OK (0) with the error flag (bit 11) clear returns `coreRdata` shifted right by 8 times offset[1:0] and masked to the access size, with code ok (0). The non-posted marker (bit 10) does not change any result.
- R9: A read with status UR (1) returns 0xFFFFFFFF and a read with status CRS (2) returns 0xFFFF0001, both with code ok. Both placeholders are then size-extracted as in R8.
- R10: Code error (1) with data zero is returned for status CA (4), for any other undefined status, for OK with the error flag set, and for UR or CRS on a write. A write with OK status and a clear error flag returns ok with data zero.
- R11: `busy` is high from the cycle after an accepted start through the result cycle. A start pulse while busy is ignored: it changes neither the core outputs nor the result, and it produces no second result.
- R12: `rspValid` is a single-cycle pulse. Each accepted request produces exactly one pulse, with a code from {ok, error, timeout}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start pulse for a new request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBus | input | 8 | Target bus number |
| reqDev | input | 5 | Target device number |
| reqFunc | input | 3 | Target function number |
| reqOffset | input | 12 | Byte offset in configuration space |
| reqSize | input | 2 | Access size: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| reqWdata | input | 32 | Right-justified write value |
| rootBus | input | 8 | Bus number of the root port |
| busy | output | 1 | A request is in progress |
| rspValid | output | 1 | Result pulse |
| rspCode | output | 2 | 0 ok, 1 error, 2 timeout |
| rspData | output | 32 | Read result, right-justified |
| coreType | output | 4 | Request type toward the core |
| coreAddrLo | output | 32 | Packed target address |
| coreAddrHi | output | 32 | Upper address word, always zero |
| coreWdata | output | 32 | Lane-aligned write data |
| coreStrb | output | 4 | Write byte strobe |
| coreClear | output | 1 | Pulse: clear start flag and write-1-clear done flag |
| coreLaunch | output | 1 | Pulse: set the start flag |
| coreStartRb | input | 1 | Start flag read back from the core |
| coreDone | input | 1 | Done flag read back from the core |
| coreStatus | input | 12 | Completion status word (bits 11:0) |
| coreRdata | input | 32 | Read data register of the core |

## Verification
The assertions assume that the core only reports a finished transfer after a launch. They also assume that `reqStart` is a clean one-cycle pulse, and that the request fields are stable during the cycle the pulse is sampled. The bench's core model raises done only a programmed number of cycles after it sees `coreLaunch`, and it drops both flags on `coreClear`. The bench drives every request field together with the start pulse on the falling edge. A start that arrives while busy is given conflicting field values on purpose, so that the check covers fields the block must not capture.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int OFS_W  = 12;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int STAT_W = 12;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;

  localparam logic [2:0] ST_OK  = 3'd0;
  localparam logic [2:0] ST_UR  = 3'd1;
  localparam logic [2:0] ST_CRS = 3'd2;

  localparam logic [DATA_W-1:0] UR_WORD  = 32'hFFFF_FFFF;
  localparam logic [DATA_W-1:0] CRS_WORD = 32'hFFFF_0001;

  typedef enum logic [1:0] {
    RSP_OK      = 2'd0,
    RSP_ERR     = 2'd1,
    RSP_TIMEOUT = 2'd2
  } rspCode_e;

  // Strobes from the sequencer into the datapath.
  typedef struct packed {
    logic capture;
    logic takeBypass;
    logic takeResult;
    logic takeTimeout;
  } seqCtl_t;

  // Right-justify the addressed bytes of a word and mask to the access size.
  function automatic logic [DATA_W-1:0] sizeExtract(
      input logic [DATA_W-1:0] word,
      input logic [1:0]        lane,
      input logic [1:0]        size);
    logic [DATA_W-1:0] shifted;
    shifted = word >> {lane, 3'b000};
    case (size)
      SIZE_BYTE: sizeExtract = {24'h0, shifted[7:0]};
      SIZE_HALF: sizeExtract = {16'h0, shifted[15:0]};
      default:   sizeExtract = shifted;
    endcase
  endfunction

endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int MAX_POLLS = 10,
  parameter int POLL_GAP  = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqStart,
  input  logic    bypass,
  input  logic    pollHit,
  output logic    busy,
  output logic    rspValid,
  output logic    coreClear,
  output logic    coreLaunch,
  output seqCtl_t ctl
);

  localparam int PIDX_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam int GAP_W  = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam logic [PIDX_W-1:0] LAST_POLL = PIDX_W'(MAX_POLLS - 1);
  localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(POLL_GAP - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CLEAR, S_LAUNCH, S_WAIT, S_RESP
  } seqState_e;

  seqState_e          state;
  logic [PIDX_W-1:0]  pollIdx;
  logic [GAP_W-1:0]   gapCnt;
  logic               pollNow;
  logic               lastPoll;

  assign pollNow  = (state == S_WAIT) && (gapCnt == '0);
  assign lastPoll = (pollIdx == LAST_POLL);

  always_comb begin
    ctl             = '0;
    ctl.capture     = (state == S_IDLE) && reqStart;
    ctl.takeBypass  = ctl.capture && bypass;
    ctl.takeResult  = pollNow && pollHit;
    ctl.takeTimeout = pollNow && !pollHit && lastPoll;
  end

  assign busy       = (state != S_IDLE);
  assign rspValid   = (state == S_RESP);
  assign coreClear  = (state == S_CLEAR);
  assign coreLaunch = (state == S_LAUNCH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollIdx <= '0;
      gapCnt  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (reqStart) state <= bypass ? S_RESP : S_CLEAR;
        end
        S_CLEAR:  state <= S_LAUNCH;
        S_LAUNCH: begin
          state   <= S_WAIT;
          pollIdx <= '0;
          gapCnt  <= '0;
        end
        S_WAIT: begin
          if (gapCnt != '0) begin
            gapCnt <= gapCnt - 1'b1;
          end else if (pollHit || lastPoll) begin
            state <= S_RESP;
          end else begin
            pollIdx <= pollIdx + 1'b1;
            gapCnt  <= GAP_LOAD;
          end
        end
        S_RESP:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_seq_dpath.sv
module cfg_seq_dpath
  import cfg_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic                reqWrite,
  input  logic [BUS_W-1:0]    reqBus,
  input  logic [DEV_W-1:0]    reqDev,
  input  logic [FUNC_W-1:0]   reqFunc,
  input  logic [OFS_W-1:0]    reqOffset,
  input  logic [1:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [BUS_W-1:0]    rootBus,
  input  logic                coreStartRb,
  input  logic                coreDone,
  input  logic [STAT_W-1:0]   coreStatus,
  input  logic [DATA_W-1:0]   coreRdata,
  output logic                bypass,
  output logic                pollHit,
  output logic [3:0]          coreType,
  output logic [DATA_W-1:0]   coreAddrLo,
  output logic [DATA_W-1:0]   coreAddrHi,
  output logic [DATA_W-1:0]   coreWdata,
  output logic [STRB_W-1:0]   coreStrb,
  output logic [1:0]          rspCode,
  output logic [DATA_W-1:0]   rspData
);

  logic                capWrite;
  logic                capType0;
  logic [BUS_W-1:0]    capBus;
  logic [DEV_W-1:0]    capDev;
  logic [FUNC_W-1:0]   capFunc;
  logic [OFS_W-1:0]    capOffset;
  logic [1:0]          capSize;
  logic [DATA_W-1:0]   capWdata;

  logic                onRoot;
  logic [2:0]          statField;
  logic                errFlag;
  logic                unusedStatBits;
  rspCode_e            resCode;
  logic [DATA_W-1:0]   resWord;
  logic [STRB_W-1:0]   sizeRun;

  assign onRoot  = (reqBus == rootBus);
  assign bypass  = onRoot && (reqDev != '0);
  assign pollHit = !coreStartRb && coreDone;

  assign statField      = coreStatus[9:7];
  assign errFlag        = coreStatus[11];
  assign unusedStatBits = ^{coreStatus[10], coreStatus[6:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWrite  <= 1'b0;
      capType0  <= 1'b1;
      capBus    <= '0;
      capDev    <= '0;
      capFunc   <= '0;
      capOffset <= '0;
      capSize   <= '0;
      capWdata  <= '0;
    end else if (ctl.capture) begin
      capWrite  <= reqWrite;
      capType0  <= onRoot;
      capBus    <= reqBus;
      capDev    <= reqDev;
      capFunc   <= reqFunc;
      capOffset <= reqOffset;
      capSize   <= reqSize;
      capWdata  <= reqWdata;
    end
  end

  // Core request fields, held from capture until the next capture.
  assign coreType   = {2'b10, capWrite, ~capType0};
  assign coreAddrLo = {4'b0000, capBus, capDev, capFunc, capOffset[OFS_W-1:2], 2'b00};
  assign coreAddrHi = '0;
  assign coreWdata  = capWdata << {capOffset[1:0], 3'b000};

  always_comb begin
    case (capSize)
      SIZE_BYTE: sizeRun = 4'b0001;
      SIZE_HALF: sizeRun = 4'b0011;
      default:   sizeRun = 4'b1111;
    endcase
  end
  assign coreStrb = sizeRun << capOffset[1:0];

  // Completion decode.
  always_comb begin
    resCode = RSP_ERR;
    resWord = '0;
    case (statField)
      ST_OK: begin
        if (!errFlag) begin
          resCode = RSP_OK;
          resWord = coreRdata;
        end
      end
      ST_UR: begin
        if (!capWrite) begin
          resCode = RSP_OK;
          resWord = UR_WORD;
        end
      end
      ST_CRS: begin
        if (!capWrite) begin
          resCode = RSP_OK;
          resWord = CRS_WORD;
        end
      end
      default: begin
        resCode = RSP_ERR;
        resWord = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspCode <= RSP_OK;
      rspData <= '0;
    end else if (ctl.takeBypass) begin
      rspCode <= RSP_OK;
      rspData <= reqWrite ? '0 : sizeExtract(UR_WORD, reqOffset[1:0], reqSize);
    end else if (ctl.takeResult) begin
      rspCode <= resCode;
      rspData <= (capWrite || resCode != RSP_OK) ? '0
                 : sizeExtract(resWord, capOffset[1:0], capSize);
    end else if (ctl.takeTimeout) begin
      rspCode <= RSP_TIMEOUT;
      rspData <= '0;
    end
  end

endmodule

// File: rtl/cfg_req_seq.sv
module cfg_req_seq
  import cfg_seq_pkg::*;
#(
  parameter int MAX_POLLS = 10,
  parameter int POLL_GAP  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqStart,
  input  logic         reqWrite,
  input  logic [7:0]   reqBus,
  input  logic [4:0]   reqDev,
  input  logic [2:0]   reqFunc,
  input  logic [11:0]  reqOffset,
  input  logic [1:0]   reqSize,
  input  logic [31:0]  reqWdata,
  input  logic [7:0]   rootBus,
  output logic         busy,
  output logic         rspValid,
  output logic [1:0]   rspCode,
  output logic [31:0]  rspData,
  output logic [3:0]   coreType,
  output logic [31:0]  coreAddrLo,
  output logic [31:0]  coreAddrHi,
  output logic [31:0]  coreWdata,
  output logic [3:0]   coreStrb,
  output logic         coreClear,
  output logic         coreLaunch,
  input  logic         coreStartRb,
  input  logic         coreDone,
  input  logic [11:0]  coreStatus,
  input  logic [31:0]  coreRdata
);

  seqCtl_t ctl;
  logic    bypass;
  logic    pollHit;

  cfg_seq_ctrl #(
    .MAX_POLLS (MAX_POLLS),
    .POLL_GAP  (POLL_GAP)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqStart   (reqStart),
    .bypass     (bypass),
    .pollHit    (pollHit),
    .busy       (busy),
    .rspValid   (rspValid),
    .coreClear  (coreClear),
    .coreLaunch (coreLaunch),
    .ctl        (ctl)
  );

  cfg_seq_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqWrite    (reqWrite),
    .reqBus      (reqBus),
    .reqDev      (reqDev),
    .reqFunc     (reqFunc),
    .reqOffset   (reqOffset),
    .reqSize     (reqSize),
    .reqWdata    (reqWdata),
    .rootBus     (rootBus),
    .coreStartRb (coreStartRb),
    .coreDone    (coreDone),
    .coreStatus  (coreStatus),
    .coreRdata   (coreRdata),
    .bypass      (bypass),
    .pollHit     (pollHit),
    .coreType    (coreType),
    .coreAddrLo  (coreAddrLo),
    .coreAddrHi  (coreAddrHi),
    .coreWdata   (coreWdata),
    .coreStrb    (coreStrb),
    .rspCode     (rspCode),
    .rspData     (rspData)
  );

endmodule

// File: rtl/cfg_req_seq_chk.sv
module cfg_req_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqStart,
  input logic        busy,
  input logic        rspValid,
  input logic [1:0]  rspCode,
  input logic [3:0]  coreType,
  input logic        coreClear,
  input logic        coreLaunch
);

  // R5: the launch pulse always directly follows a clear pulse
  a_r5_launch_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    coreLaunch |-> $past(coreClear));

  // R5: clear and launch never overlap
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(coreClear && coreLaunch));

  // R12: result is a single-cycle pulse
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R12: result code is one of the three defined codes
  a_r12_code_range: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspCode != 2'd3));

  // R11: a result only appears while busy, and busy ends right after it
  a_r11_busy_cover: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy);

  a_r11_busy_ends: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !busy);

  // R11: a start while busy does not disturb the issued request type
  a_r11_type_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(reqStart)) |-> $stable(coreType));

  // R4/R5: clear is only ever requested on the cycle after busy rises
  a_r5_clear_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    coreClear |-> (busy && $past(!busy)));

endmodule

bind cfg_req_seq cfg_req_seq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqStart   (reqStart),
  .busy       (busy),
  .rspValid   (rspValid),
  .rspCode    (rspCode),
  .coreType   (coreType),
  .coreClear  (coreClear),
  .coreLaunch (coreLaunch)
);

// File: tb/cfg_req_seq_tb.sv
`timescale 1ns/1ps
module cfg_req_seq_tb;

  localparam int MAXP = 10;
  localparam int GAP  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [11:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic [7:0]  rootBus = '0;
  logic        busy, rspValid, coreClear, coreLaunch;
  logic [1:0]  rspCode;
  logic [31:0] rspData, coreAddrLo, coreAddrHi, coreWdata;
  logic [3:0]  coreType, coreStrb;
  logic        coreStartRb = 1'b0;
  logic        coreDone = 1'b0;
  logic [11:0] coreStatus = '0;
  logic [31:0] coreRdata = '0;

  int coreLat = 1;
  int latCnt  = 0;
  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  cfg_req_seq #(.MAX_POLLS(MAXP), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqOffset(reqOffset),
    .reqSize(reqSize), .reqWdata(reqWdata), .rootBus(rootBus),
    .busy(busy), .rspValid(rspValid), .rspCode(rspCode), .rspData(rspData),
    .coreType(coreType), .coreAddrLo(coreAddrLo), .coreAddrHi(coreAddrHi),
    .coreWdata(coreWdata), .coreStrb(coreStrb), .coreClear(coreClear),
    .coreLaunch(coreLaunch), .coreStartRb(coreStartRb), .coreDone(coreDone),
    .coreStatus(coreStatus), .coreRdata(coreRdata));

  // Behavioural core: flags set by launch, done after coreLat cycles (0 = never).
  always @(posedge clk) begin
    if (!rstN) begin
      coreStartRb <= 1'b0; coreDone <= 1'b0; latCnt <= 0;
    end else if (coreClear) begin
      coreStartRb <= 1'b0; coreDone <= 1'b0;
    end else if (coreLaunch) begin
      coreStartRb <= 1'b1; latCnt <= coreLat;
    end else if (coreStartRb && latCnt == 1) begin
      coreStartRb <= 1'b0; coreDone <= 1'b1;
    end else if (coreStartRb && latCnt > 1) begin
      latCnt <= latCnt - 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (!ok) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] extract(input logic [31:0] w, input int lane, input int sz);
    logic [31:0] s;
    s = w >> (8 * lane);
    if (sz == 0) return s & 32'hFF;
    if (sz == 1) return s & 32'hFFFF;
    return s;
  endfunction

  // One request, checked on every cycle until one cycle past its result.
  task automatic access(input bit wr, input int bus, input int dev, input int fn,
                        input int ofs, input int sz, input logic [31:0] wd,
                        input int lat, input logic [11:0] st, input logic [31:0] rd,
                        input int expCode, input logic [31:0] expData,
                        input bit poke, input string req);
    bit          isBypass;
    int          mExp, k, bytes;
    logic [3:0]  expType, expStrb;
    logic [31:0] expAddr, expWd;
    @(negedge clk);
    reqWrite = wr; reqBus = 8'(bus); reqDev = 5'(dev); reqFunc = 3'(fn);
    reqOffset = 12'(ofs); reqSize = 2'(sz); reqWdata = wd;
    coreLat = lat; coreStatus = st; coreRdata = rd;
    reqStart = 1'b1;
    isBypass = (8'(bus) == rootBus) && (dev != 0);
    expType  = {2'b10, wr, (8'(bus) == rootBus) ? 1'b0 : 1'b1};
    expAddr  = {4'h0, 8'(bus), 5'(dev), 3'(fn), 12'(ofs) & 12'hFFC};
    bytes    = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    expStrb  = 4'(((1 << bytes) - 1) << (ofs % 4));
    expWd    = wd << (8 * (ofs % 4));
    if (isBypass) mExp = 0;
    else begin
      k = (lat == 0) ? MAXP : (lat + GAP - 1) / GAP;
      mExp = (k >= MAXP) ? 3 + (MAXP - 1) * GAP : 3 + k * GAP;
    end
    for (int m = 0; m <= mExp + 1; m++) begin
      @(negedge clk);
      if (m == 0) reqStart = 1'b0;
      if (poke && m == 5) begin
        reqStart = 1'b1; reqBus = 8'h77; reqWrite = ~wr; reqOffset = 12'h3;
      end
      if (poke && m == 6) reqStart = 1'b0;
      chk(busy == (m <= mExp), {req, " R11 busy"}, 32'(busy), 32'(m <= mExp));
      chk(rspValid == (m == mExp), {req, " R12 rspValid"}, 32'(rspValid), 32'(m == mExp));
      if (isBypass) begin
        chk(!coreClear && !coreLaunch, {req, " R4 not issued"},
            32'({coreClear, coreLaunch}), 32'h0);
      end else begin
        if (m == 0) begin
          chk(coreClear, {req, " R5 clear"}, 32'(coreClear), 32'h1);
          chk(coreType == expType, {req, " R1 type"}, 32'(coreType), 32'(expType));
          chk(coreAddrLo == expAddr, {req, " R2 addr"}, coreAddrLo, expAddr);
          chk(coreAddrHi == 32'h0, {req, " R2 addrHi"}, coreAddrHi, 32'h0);
          if (wr) begin
            chk(coreStrb == expStrb, {req, " R3 strb"}, 32'(coreStrb), 32'(expStrb));
            chk(coreWdata == expWd, {req, " R3 wdata"}, coreWdata, expWd);
          end
        end
        if (m == 1) chk(coreLaunch && !coreClear, {req, " R5 launch"},
                        32'({coreClear, coreLaunch}), 32'h1);
        if (m == mExp) chk(coreType == expType, {req, " R11 type held"},
                           32'(coreType), 32'(expType));
      end
      if (m == mExp) begin
        chk(rspCode == 2'(expCode), {req, " code"}, 32'(rspCode), 32'(expCode));
        chk(rspData == expData, {req, " data"}, rspData, expData);
      end
    end
  endtask

  localparam logic [11:0] S_OK  = 12'h000;
  localparam logic [11:0] S_UR  = 12'h080;
  localparam logic [11:0] S_CRS = 12'h100;
  localparam logic [11:0] S_CA  = 12'h200;
  localparam logic [11:0] S_UNK = 12'h180;
  localparam logic [11:0] S_ERR = 12'h800;
  localparam logic [11:0] S_NP  = 12'h400;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !rspValid && !coreClear && !coreLaunch, "R11 reset idle",
        32'({busy, rspValid, coreClear, coreLaunch}), 32'h0);

    // R1 R2 R8: type-0 word read, OK
    access(0, 0, 0, 2, 'h10, 2, 0, 3, S_OK, 32'h1234_5678, 0, 32'h1234_5678, 0, "R8 rd t0");
    // R1 R8: type-1 half read at lane 2, non-posted marker set
    access(0, 5, 3, 1, 'h46, 1, 0, 1, S_NP, 32'hAABB_CCDD, 0, 32'h0000_AABB, 0, "R8 rd t1 half");
    // R8: byte read at lane 3
    access(0, 1, 0, 0, 'h03, 0, 0, 8, S_OK, 32'h1122_3344, 0, 32'h0000_0011, 0, "R8 rd byte");
    // R3: type-0 byte write at lane 1
    access(1, 0, 0, 0, 'h21, 0, 32'h5A, 2, S_OK, 0, 0, 0, 0, "R3 wr byte");
    // R3 R1: type-1 half write at lane 2
    access(1, 2, 4, 7, 'hFE, 1, 32'hBEEF, 5, S_OK, 0, 0, 0, 0, "R3 wr half");
    access(1, 2, 4, 7, 'h80, 2, 32'hCAFE_F00D, 5, S_OK, 0, 0, 0, 0, "R3 wr word");
    // R9: placeholders
    access(0, 0, 0, 0, 'h0, 2, 0, 2, S_UR, 32'h1, 0, 32'hFFFF_FFFF, 0, "R9 UR read");
    access(0, 0, 0, 0, 'h0, 2, 0, 2, S_CRS, 32'h1, 0, 32'hFFFF_0001, 0, "R9 CRS read");
    access(0, 0, 0, 0, 'h2, 1, 0, 2, S_CRS, 32'h1, 0, 32'h0000_FFFF, 0, "R9 CRS half");
    // R10: errors
    access(1, 0, 0, 0, 'h4, 2, 32'h1, 2, S_UR, 0, 1, 0, 0, "R10 UR write");
    access(1, 3, 0, 0, 'h4, 2, 32'h1, 2, S_CRS, 0, 1, 0, 0, "R10 CRS write");
    access(0, 0, 0, 0, 'h8, 2, 0, 2, S_CA, 32'h55, 1, 0, 0, "R10 CA read");
    access(0, 0, 0, 0, 'h8, 2, 0, 2, S_UNK, 32'h55, 1, 0, 0, "R10 unknown");
    access(0, 0, 0, 0, 'h8, 2, 0, 2, S_ERR, 32'h55, 1, 0, 0, "R10 OK+err read");
    access(1, 0, 0, 0, 'h8, 2, 32'h9, 2, S_ERR, 0, 1, 0, 0, "R10 OK+err write");
    // R4: root bus, non-zero device
    access(0, 0, 3, 0, 'h1, 0, 0, 2, S_OK, 32'h0, 0, 32'h0000_00FF, 0, "R4 bypass byte");
    access(0, 0, 31, 1, 'h0, 2, 0, 2, S_OK, 32'h0, 0, 32'hFFFF_FFFF, 0, "R4 bypass word");
    access(1, 0, 1, 0, 'h0, 2, 32'h7, 2, S_OK, 0, 0, 0, 0, "R4 bypass write");
    rootBus = 8'd7;
    access(0, 7, 2, 0, 'h2, 1, 0, 2, S_OK, 0, 0, 32'h0000_FFFF, 0, "R4 bypass root7");
    access(0, 0, 1, 0, 'h0, 2, 0, 2, S_OK, 32'hDEAD_BEEF, 0, 32'hDEAD_BEEF, 0, "R1 bus0 t1");
    rootBus = 8'd0;
    // R6 R7: poll window edges
    access(0, 0, 0, 0, 'h0, 2, 0, 36, S_OK, 32'hA5A5_0000, 0, 32'hA5A5_0000, 0, "R6 last poll hit");
    access(0, 0, 0, 0, 'h0, 2, 0, 37, S_OK, 32'hA5A5_0000, 2, 0, 0, "R7 timeout late");
    access(1, 0, 0, 0, 'h0, 2, 32'h1, 0, S_OK, 0, 2, 0, 0, "R7 timeout never");
    // R11: start while busy ignored
    access(0, 4, 2, 3, 'h44, 2, 0, 9, S_OK, 32'h0BAD_F00D, 0, 32'h0BAD_F00D, 1, "R11 start busy");
    access(0, 0, 0, 0, 'h0, 2, 0, 1, S_OK, 32'h0000_0042, 0, 32'h0000_0042, 0, "R12 after poke");

    summary();
    $finish;
  end

endmodule